// File: doc/BRIEF.md
# Nine-Bit Address-Filtering Serial Node

This block is a paired asynchronous serial transmitter and receiver for a shared multi-drop line on which every character carries nine bits and no parity. The ninth bit splits traffic into two kinds. When it is 1 the character is an address. When it is 0 the character is data. A node that is not being addressed can arm an attention filter. While the filter is armed, the hardware throws away all data characters. The first address character that arrives is stored and flagged, and the filter then disarms itself. Software reads that address and decides what to do next. To accept the data that follows, it leaves the filter disarmed. To ignore the data and wait for the next address, it pulses `attn_arm`.

A loopback mode feeds the transmitter output straight into the receiver. In this mode the external transmit pin is held at the idle level 1 and the external receive pin is ignored. The line can be set up for one or two start bits and for one or two stop bits. Both directions use the same setting.

One bit lasts 16 oversampling ticks, and one tick lasts `DIV` clock cycles. Bits go out and come in least significant bit first, and the ninth bit is last.

The transmitter state machine has four states:
- `TX_IDLE` moves to `TX_START` when a load arrives.
- `TX_START` stays in place for a second start bit if two are configured. Otherwise it moves to `TX_DATA`.
- `TX_DATA` moves to `TX_STOP` after nine bits.
- `TX_STOP` stays in place for a second stop bit if two are configured. Otherwise it returns to `TX_IDLE`.

The receiver state machine also has four states:
- `RX_IDLE` moves to `RX_START` on a falling edge of the line.
- `RX_START` returns to `RX_IDLE` if the mid-bit sample is high, which marks a false start. It stays in place for a second start bit if two are configured. Otherwise it moves to `RX_DATA`.
- `RX_DATA` moves to `RX_STOP` after nine centre samples.
- `RX_STOP` returns to `RX_IDLE` when a stop sample is 0, which is a framing error. It also returns to `RX_IDLE` after the last stop bit, and it delivers the character on that transition.

Top module: `nine_bit_node_uart`

## Requirements
- R1: After reset, `tx_pin`=1, `tx_busy`=0, `rx_full`=0, `attn`=0, `frame_err`=0 and `irq`=0.
- R2: The transmit frame has the following parts, in order:
  - the start bits at 0, one of them, or two if `two_start`=1;
  - nine bits, least significant first, with `tx_data` in bits 0..7 and `tx_bit9` as bit 8;
  - the stop bits at 1, one of them, or two if `two_stop`=1.

  Each bit lasts 16*DIV clocks. `tx_busy` is 1 for the whole frame.
- R3: A `tx_load` that arrives while `tx_busy`=1 is ignored, and the frame in progress goes out unchanged.
- R4: When `attn`=0, every character received with valid stop bits is delivered. The low eight bits go to `rx_data`, the ninth bit goes to `rx_bit9`, and `rx_full` is set. The receiver honours the same start-bit and stop-bit counts as the transmitter.
- R5: When `attn`=1, a received character whose ninth bit is 0 is dropped. `rx_data`, `rx_bit9`, `rx_full` and `attn` do not change.
- R6: When `attn`=1, a received character whose ninth bit is 1 is delivered as in R4, and `attn` returns to 0.
- R7: A one-cycle pulse on `attn_arm` sets `attn` to 1. If the same cycle also delivers an address, the pulse takes priority.
- R8: `irq` is 1 exactly when `rx_full`=1 and `irq_en`=1.
- R9: A one-cycle pulse on `rx_read` clears both `rx_full` and `frame_err`.
- R10: A stop bit sampled as 0 sets `frame_err`. The character is not delivered, and `attn` does not change.
- R11: When `loop_en`=1, the transmitter drives the receiver internally. `tx_pin` stays at 1 and `rx_pin` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loop_en | input | 1 | Internal transmit-to-receive loopback |
| two_start | input | 1 | Two start bits instead of one |
| two_stop | input | 1 | Two stop bits instead of one |
| irq_en | input | 1 | Interrupt enable |
| attn_arm | input | 1 | Pulse that arms the address filter |
| tx_data | input | 8 | Low eight bits of the character to send |
| tx_bit9 | input | 1 | Ninth bit to send (1 = address) |
| tx_load | input | 1 | Pulse that starts a transmission |
| tx_busy | output | 1 | Transmitter frame in progress |
| tx_pin | output | 1 | Serial output line |
| rx_pin | input | 1 | Serial input line |
| rx_read | input | 1 | Pulse that acknowledges the receive buffer |
| rx_data | output | 8 | Received low eight bits |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_full | output | 1 | Receive buffer holds an unread character |
| attn | output | 1 | Address filter armed |
| frame_err | output | 1 | Stop bit was sampled low |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is one that combines three things:
- the filter is armed;
- an earlier character is still unread in the buffer;
- a data character, a malformed character or an address character then arrives.

In that situation only the address character may touch the buffer or the flag, and the other two must leave no trace. The random phase covers this. Before each frame it arms the filter, acknowledges the buffer, changes the start and stop counts, and corrupts the stop bit, each by independent draws. It then compares all receive outputs with a bench model after every frame. Directed passes add a load issued in the middle of a frame and loopback traffic sent while `rx_pin` is held low.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
    localparam int unsigned OVS     = 16;
    localparam int unsigned OVS_W   = $clog2(OVS);
    localparam int unsigned CHAR_W  = 9;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    typedef struct packed {
        logic       mark;
        logic [7:0] payload;
    } char_t;
endpackage

// File: rtl/uart9_tick.sv
module uart9_tick #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (cnt == CW'(DIV - 1))   cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CW'(DIV - 1));
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
    import uart9_pkg::*;
#(
    parameter int unsigned W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         two_start,
    input  logic         two_stop,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic         line,
    output logic         busy
);
    localparam int unsigned BW = $clog2(W + 1);

    tx_state_e          st, nx;
    logic [OVS_W-1:0]   tcnt;
    logic [BW-1:0]      bcnt;
    logic [W-1:0]       sh;
    logic               bit_end;

    assign bit_end = tick && (tcnt == OVS_W'(OVS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            TX_IDLE:  if (load) nx = TX_START;
            TX_START: if (bit_end && !(two_start && bcnt == '0)) nx = TX_DATA;
            TX_DATA:  if (bit_end && bcnt == BW'(W - 1)) nx = TX_STOP;
            TX_STOP:  if (bit_end && !(two_stop && bcnt == '0)) nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
            bcnt <= '0;
            sh   <= '0;
        end else if (st == TX_IDLE) begin
            tcnt <= '0;
            bcnt <= '0;
            if (load) sh <= word;
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
            if (bit_end) begin
                bcnt <= (nx != st) ? '0 : bcnt + 1'b1;
                if (st == TX_DATA) sh <= sh >> 1;
            end
        end
    end

    always_comb begin
        line = 1'b1;
        unique case (st)
            TX_IDLE:  line = 1'b1;
            TX_START: line = 1'b0;
            TX_DATA:  line = sh[0];
            TX_STOP:  line = 1'b1;
        endcase
    end

    assign busy = (st != TX_IDLE);
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
#(
    parameter int unsigned W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         two_start,
    input  logic         two_stop,
    input  logic         line,
    output logic         done,
    output logic         ok,
    output logic [W-1:0] word
);
    localparam int unsigned BW = $clog2(W + 1);

    rx_state_e          st, nx;
    logic [OVS_W-1:0]   tcnt;
    logic [BW-1:0]      bcnt;
    logic [W-1:0]       sh;
    logic               line_q;
    logic               samp;
    logic               fall;

    assign samp = tick && (tcnt == OVS_W'(OVS - 1));
    assign fall = line_q && !line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            RX_IDLE:  if (fall) nx = RX_START;
            RX_START: if (samp) begin
                          if (line)                             nx = RX_IDLE;
                          else if (!(two_start && bcnt == '0))  nx = RX_DATA;
                      end
            RX_DATA:  if (samp && bcnt == BW'(W - 1)) nx = RX_STOP;
            RX_STOP:  if (samp && (!line || !(two_stop && bcnt == '0))) nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt   <= '0;
            bcnt   <= '0;
            sh     <= '0;
            line_q <= 1'b1;
        end else begin
            line_q <= line;
            if (st == RX_IDLE) begin
                tcnt <= OVS_W'(OVS / 2);
                bcnt <= '0;
            end else if (tick) begin
                tcnt <= tcnt + 1'b1;
                if (samp) begin
                    bcnt <= (nx != st) ? '0 : bcnt + 1'b1;
                    if (st == RX_DATA) sh <= {line, sh[W-1:1]};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            ok   <= 1'b0;
            word <= '0;
        end else begin
            done <= (st == RX_STOP) && (nx == RX_IDLE);
            ok   <= line;
            word <= sh;
        end
    end
endmodule

// File: rtl/nine_bit_node_uart.sv
module nine_bit_node_uart
    import uart9_pkg::*;
#(
    parameter int unsigned DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loop_en,
    input  logic       two_start,
    input  logic       two_stop,
    input  logic       irq_en,
    input  logic       attn_arm,
    input  logic [7:0] tx_data,
    input  logic       tx_bit9,
    input  logic       tx_load,
    output logic       tx_busy,
    output logic       tx_pin,
    input  logic       rx_pin,
    input  logic       rx_read,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       rx_full,
    output logic       attn,
    output logic       frame_err,
    output logic       irq
);
    logic        tick;
    logic        tx_line;
    logic [1:0]  rx_sync;
    logic        rx_done;
    logic        rx_ok;
    char_t       rx_char;
    char_t       tx_char;

    assign tx_char = '{mark: tx_bit9, payload: tx_data};

    uart9_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    uart9_tx #(.W(CHAR_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .two_start (two_start),
        .two_stop  (two_stop),
        .load      (tx_load && !tx_busy),
        .word      (tx_char),
        .line      (tx_line),
        .busy      (tx_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_sync <= 2'b11;
        else        rx_sync <= {rx_sync[0], loop_en ? tx_line : rx_pin};
    end

    uart9_rx #(.W(CHAR_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .two_start (two_start),
        .two_stop  (two_stop),
        .line      (rx_sync[1]),
        .done      (rx_done),
        .ok        (rx_ok),
        .word      (rx_char)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            rx_full   <= 1'b0;
            attn      <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            if (rx_read) begin
                rx_full   <= 1'b0;
                frame_err <= 1'b0;
            end
            if (rx_done) begin
                if (!rx_ok) begin
                    frame_err <= 1'b1;
                end else if (!attn || rx_char.mark) begin
                    rx_data <= rx_char.payload;
                    rx_bit9 <= rx_char.mark;
                    rx_full <= 1'b1;
                    if (rx_char.mark) attn <= 1'b0;
                end
            end
            if (attn_arm) attn <= 1'b1;
        end
    end

    assign tx_pin = loop_en ? 1'b1 : tx_line;
    assign irq    = rx_full && irq_en;
endmodule

// File: rtl/uart9_node_chk.sv
module uart9_node_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loop_en,
    input logic       tx_load,
    input logic       tx_busy,
    input logic       tx_pin,
    input logic [7:0] rx_data,
    input logic       rx_bit9,
    input logic       rx_full,
    input logic       attn,
    input logic       frame_err
);
    // R6
    attn_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(attn) && !attn) |-> (rx_full && rx_bit9));

    // R5
    no_data_while_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> (!$past(attn) || rx_bit9));

    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !loop_en) |-> tx_pin);

    // R2
    load_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !tx_busy) |=> tx_busy);

    // R10
    bad_stop_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> ($stable(rx_data) && $stable(rx_bit9)));
endmodule

bind nine_bit_node_uart uart9_node_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_en   (loop_en),
    .tx_load   (tx_load),
    .tx_busy   (tx_busy),
    .tx_pin    (tx_pin),
    .rx_data   (rx_data),
    .rx_bit9   (rx_bit9),
    .rx_full   (rx_full),
    .attn      (attn),
    .frame_err (frame_err)
);

// File: tb/nine_bit_node_uart_test.sv
module nine_bit_node_uart_test;
    localparam int DIV = 4;
    localparam int BIT = 16 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loop_en = 0, two_start = 0, two_stop = 0, irq_en = 0, attn_arm = 0;
    logic [7:0] tx_data = 0;
    logic tx_bit9 = 0, tx_load = 0, rx_pin = 1, rx_read = 0;
    logic tx_busy, tx_pin, rx_bit9, rx_full, attn, frame_err, irq;
    logic [7:0] rx_data;

    int checks = 0, fails = 0;
    bit reported = 0;

    logic [7:0] m_data = 0;
    logic m_b9 = 0, m_full = 0, m_attn = 0, m_ferr = 0;

    always #2.5 clk = ~clk;

    nine_bit_node_uart #(.DIV(DIV)) uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    endtask

    function automatic int nstart(); return two_start ? 2 : 1; endfunction
    function automatic int nstop();  return two_stop  ? 2 : 1; endfunction

    // Bench model of the receive path (R4, R5, R6, R10)
    task automatic model_rx(logic [8:0] w, bit bad);
        if (bad) m_ferr = 1;
        else if (!m_attn || w[8]) begin
            m_data = w[7:0]; m_b9 = w[8]; m_full = 1;
            if (w[8]) m_attn = 0;
        end
    endtask

    task automatic check_rx(string req);
        chk({req, " rx_full"},   rx_full,   m_full);
        chk({req, " rx_data"},   rx_data,   m_data);
        chk({req, " rx_bit9"},   rx_bit9,   m_b9);
        chk({req, " attn"},      attn,      m_attn);
        chk({req, " frame_err"}, frame_err, m_ferr);
        chk("R8 irq",            irq,       m_full && irq_en);
    endtask

    task automatic pulse_arm();
        attn_arm = 1; @(negedge clk); attn_arm = 0; m_attn = 1;
    endtask

    task automatic pulse_read();
        rx_read = 1; @(negedge clk); rx_read = 0; m_full = 0; m_ferr = 0;
    endtask

    task automatic send_rx(logic [8:0] w, bit bad);
        rx_pin = 0; repeat (nstart() * BIT) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            rx_pin = w[i]; repeat (BIT) @(negedge clk);
        end
        rx_pin = !bad; repeat (BIT) @(negedge clk);
        rx_pin = 1;
        if (two_stop) repeat (BIT) @(negedge clk);
        repeat (BIT) @(negedge clk);
        model_rx(w, bad);
    endtask

    task automatic cap_tx(output logic [8:0] w, output bit good);
        good = 1; w = '0;
        while (tx_pin !== 1'b0) @(negedge clk);
        repeat (BIT / 2) @(negedge clk);
        if (tx_pin !== 1'b0) good = 0;
        if (two_start) begin
            repeat (BIT) @(negedge clk);
            if (tx_pin !== 1'b0) good = 0;
        end
        for (int i = 0; i < 9; i++) begin
            repeat (BIT) @(negedge clk);
            w[i] = tx_pin;
        end
        repeat (BIT) @(negedge clk);
        if (tx_pin !== 1'b1) good = 0;
        if (two_stop) begin
            repeat (BIT) @(negedge clk);
            if (tx_pin !== 1'b1) good = 0;
        end
    endtask

    task automatic load_tx(logic [8:0] w);
        tx_data = w[7:0]; tx_bit9 = w[8]; tx_load = 1;
        @(negedge clk); tx_load = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        logic [8:0] got;
        bit good;
        void'($urandom(32'h5EED_0009));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tx_pin", tx_pin, 1); chk("R1 tx_busy", tx_busy, 0);
        chk("R1 rx_full", rx_full, 0); chk("R1 attn", attn, 0);
        chk("R1 frame_err", frame_err, 0); chk("R1 irq", irq, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);

        // R4 plain receive, R8 irq
        irq_en = 1;
        send_rx(9'h0A5, 0); check_rx("R4");
        // R9 read clears
        pulse_read(); check_rx("R9");
        // R7 arm, R5 data dropped, R6 address accepted
        pulse_arm(); chk("R7 attn", attn, 1);
        send_rx(9'h033, 0); check_rx("R5");
        send_rx(9'h17E, 0); check_rx("R6");
        // R10 framing error while armed
        pulse_arm(); send_rx(9'h1C3, 1); check_rx("R10");
        pulse_read();

        // R2 transmit frames, both count settings
        for (int k = 0; k < 4; k++) begin
            logic [8:0] w;
            two_start = k[0]; two_stop = k[1];
            w = 9'($urandom);
            fork
                cap_tx(got, good);
                begin @(negedge clk); load_tx(w); chk("R2 tx_busy", tx_busy, 1); end
            join
            chk("R2 tx word", got, w); chk("R2 tx framing", good, 1);
            while (tx_busy) @(negedge clk);
        end

        // R3 load while busy ignored
        two_start = 0; two_stop = 0;
        fork
            cap_tx(got, good);
            begin
                @(negedge clk); load_tx(9'h155);
                repeat (3 * BIT) @(negedge clk); load_tx(9'h0AA);
            end
        join
        chk("R3 tx word", got, 9'h155); chk("R3 framing", good, 1);
        while (tx_busy) @(negedge clk);
        repeat (2 * BIT) @(negedge clk);
        chk("R3 line idle", tx_pin, 1);

        // R11 loopback: rx_pin held low and ignored, tx_pin held high
        loop_en = 1; rx_pin = 0;
        repeat (14 * BIT) @(negedge clk); check_rx("R11 ignore");
        for (int k = 0; k < 3; k++) begin
            logic [8:0] w;
            int lows;
            w = (k == 1) ? 9'h044 : 9'($urandom) | 9'h100;
            if (k == 1) pulse_arm();
            lows = 0;
            load_tx(w);
            while (tx_busy) begin if (tx_pin !== 1'b1) lows++; @(negedge clk); end
            repeat (BIT) @(negedge clk);
            chk("R11 tx_pin high", lows, 0);
            model_rx(w, 0); check_rx("R11");
            pulse_read();
        end
        rx_pin = 1; repeat (BIT) @(negedge clk); loop_en = 0;
        repeat (BIT) @(negedge clk);

        // Random mix for R4 R5 R6 R7 R8 R9 R10
        for (int n = 0; n < 60; n++) begin
            logic [8:0] w;
            bit bad;
            two_start = ($urandom % 2) == 0;
            two_stop  = ($urandom % 2) == 0;
            irq_en    = ($urandom % 2) == 0;
            if ($urandom % 3 == 0) pulse_arm();
            if ($urandom % 3 == 0) pulse_read();
            w = 9'($urandom);
            bad = ($urandom % 8) == 0;
            send_rx(w, bad);
            check_rx(bad ? "R10" : (m_attn ? "R5" : (w[8] ? "R6" : "R4")));
        end
        report();
    end
endmodule